// File: doc/BRIEF.md
# Banked Nibble Register File

This block is the general register store of a 4-bit processor core. It keeps four banks of eight 4-bit registers. A one-bit bank-enable flag and a two-bit bank-select field together pick the bank that every register access uses. The active bank number is the select field ANDed bit by bit with the enable flag. Clearing the flag therefore falls back to bank 0 but keeps the select value, so setting the flag again returns to the chosen bank.

One write port takes either a single nibble or an 8-bit register pair. Two independent combinational read ports return a nibble, zero-extended to 8 bits, or a pair. Bank state is changed by separate set, clear and load commands. For interrupt handling, the full bank state can be pushed onto a small internal save stack and popped back on return. An interrupt-entry strobe loads the enable flag from a value that comes with the vector.

Register index encoding, used by every nibble access: X=0, A=1, B=2, C=3, D=4, E=5, H=6, L=7. Pair index encoding, taken from the low two bits of the index: 0=XA, 1=BC, 2=DE, 3=HL. In each pair, the even register is the high nibble and the odd register is the low nibble.

Top module: `nib_bank_regfile`

## Requirements
- R1: After reset every register in every bank reads 0, `bank_en`, `bank_sel` and `bank_act` are 0, the save stack is empty and `stk_err` is 0.
- R2: A nibble write (`wr_pair`=0) to index r stores `wr_data[3:0]` in register r of the active bank. A nibble read of r then returns it in bits [3:0], with bits [7:4] at 0, using the encoding X=0 to L=7.
- R3: `bank_act` equals `bank_sel` ANDed with `bank_en`. While `bank_en` is 0, all accesses use bank 0 and `bank_sel` keeps its value. `bank_sel` changes only by a select load or a pop.
- R4: `en_set` makes `bank_en` 1 and `en_clr` makes it 0, both from the next cycle. When both are given together, set wins. `sel_ld` loads `sel_val` into `bank_sel` from the next cycle.
- R5: Pair p covers registers 2p (high nibble, bits [7:4]) and 2p+1 (low nibble, bits [3:0]). A pair write updates both registers in one cycle, and a pair read returns both together.
- R6: The two read ports address registers independently. A read in the same cycle as a write to the same register returns the value held before the write.
- R7: A register write issued in the same cycle as any bank-state change (select, enable, interrupt entry, pop) goes to the bank that was active before the change.
- R8: `irq_entry` loads `irq_en_val` into `bank_en` from the next cycle, overriding `en_set` and `en_clr`, and leaves `bank_sel` as it is.
- R9: `sv_push` saves {`bank_en`,`bank_sel`} on the save stack. `sv_pop` restores the most recently saved entry into both from the next cycle, overriding every other bank-state command. The stack holds 4 entries, last in first out.
- R10: A push onto a full stack, a pop from an empty stack, or a push and pop together raises `stk_err` for exactly the next cycle. In each of these cases the stack contents are unchanged, and the bank state follows the non-stack commands only.
- R11: A write in one bank leaves the same register in every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | 1 | Set bank-enable flag |
| en_clr | input | 1 | Clear bank-enable flag |
| sel_ld | input | 1 | Load bank-select field |
| sel_val | input | 2 | New bank-select value |
| irq_entry | input | 1 | Interrupt entry strobe |
| irq_en_val | input | 1 | Enable value supplied by the vector |
| sv_push | input | 1 | Push bank state onto save stack |
| sv_pop | input | 1 | Pop bank state from save stack |
| wr_en | input | 1 | Register write strobe |
| wr_pair | input | 1 | 1: pair write, 0: nibble write |
| wr_idx | input | 3 | Register index, or pair index in bits [1:0] |
| wr_data | input | 8 | Write data (nibble in [3:0]) |
| rd0_pair | input | 1 | Read port 0 pair mode |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_data | output | 8 | Read port 0 data |
| rd1_pair | input | 1 | Read port 1 pair mode |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_data | output | 8 | Read port 1 data |
| bank_en | output | 1 | Current bank-enable flag |
| bank_sel | output | 2 | Current bank-select field |
| bank_act | output | 2 | Effective bank number |
| stk_err | output | 1 | Save-stack misuse, one-cycle pulse |

## Verification
The assertions assume that every command input is 0 or 1 at each clock edge and is never X. They do not assume the commands are mutually exclusive: the stack and state properties include the conflicting cases, and the pop override is tested directly. The stimulus drives all inputs on the falling edge and returns them to idle after every rising edge. It deliberately pairs set with clear, select with write, and push with pop, so the priority rules are exercised rather than avoided.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  localparam int SEL_W = 2;
  localparam int NBANK = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } bank_st_t;

  localparam int ST_W = $bits(bank_st_t);
endpackage

// File: rtl/nrf_save_stack.sv
module nrf_save_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] pop_data,
  output logic         pop_ok,
  output logic         err
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full, empty, do_push, misuse;
  logic [IDX_W-1:0] top_idx;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !pop && !full;
  assign pop_ok  = pop && !push && !empty;
  assign misuse  = (push && pop) || (push && full) || (pop && empty);
  assign top_idx = IDX_W'(cnt - CNT_W'(1));
  assign pop_data = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (do_push) mem[cnt[IDX_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      err <= misuse;
      if (do_push)     cnt <= cnt + CNT_W'(1);
      else if (pop_ok) cnt <= cnt - CNT_W'(1);
    end
  end

  // R10: a rejected stack command raises the error and keeps the depth
  p_misuse_r10: assert property (@(posedge clk) disable iff (rst)
    misuse |=> (err && $stable(cnt)));
  // R9: depth never exceeds the stack size
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/nrf_bank_ctrl.sv
module nrf_bank_ctrl
  import nrf_pkg::*;
#(
  parameter int STK_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             sel_ld,
  input  logic [SEL_W-1:0] sel_val,
  input  logic             irq_entry,
  input  logic             irq_en_val,
  input  logic             push,
  input  logic             pop,
  output bank_st_t         cur,
  output logic             stk_err
);
  logic            pop_ok;
  logic [ST_W-1:0] pop_data;

  nrf_save_stack #(.DEPTH(STK_DEPTH), .W(ST_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_data (cur),
    .pop_data  (pop_data),
    .pop_ok    (pop_ok),
    .err       (stk_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (pop_ok) begin
      cur <= bank_st_t'(pop_data);
    end else begin
      if (irq_entry)   cur.en <= irq_en_val;
      else if (en_set) cur.en <= 1'b1;
      else if (en_clr) cur.en <= 1'b0;
      if (sel_ld)      cur.sel <= sel_val;
    end
  end

  // R4: set command (not overridden) turns the enable on
  p_set_en_r4: assert property (@(posedge clk) disable iff (rst)
    (en_set && !irq_entry && !pop_ok) |=> cur.en);
  // R8: interrupt entry takes the vector's enable value
  p_irq_en_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_entry && !pop_ok) |=> (cur.en == $past(irq_en_val)));
  // R3: select only moves on a load or a pop
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!sel_ld && !pop_ok) |=> $stable(cur.sel));
  // R9: a pop restores the saved entry in full
  p_pop_restore_r9: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> (cur == bank_st_t'($past(pop_data))));
endmodule

// File: rtl/nrf_reg_half.sv
module nrf_reg_half #(
  parameter int NIB_W = 4,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NIB_W-1:0] wdata,
  input  logic [AW-1:0]    raddr0,
  input  logic [AW-1:0]    raddr1,
  output logic [NIB_W-1:0] rdata0,
  output logic [NIB_W-1:0] rdata1
);
  localparam int DEPTH = 1 << AW;

  logic [NIB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

  // R2: a write is visible at its address on the following cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/nib_bank_regfile.sv
module nib_bank_regfile
  import nrf_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int NREG      = 8,
  parameter int STK_DEPTH = 4,
  parameter int RIDX_W    = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_set,
  input  logic                 en_clr,
  input  logic                 sel_ld,
  input  logic [SEL_W-1:0]     sel_val,
  input  logic                 irq_entry,
  input  logic                 irq_en_val,
  input  logic                 sv_push,
  input  logic                 sv_pop,
  input  logic                 wr_en,
  input  logic                 wr_pair,
  input  logic [RIDX_W-1:0]    wr_idx,
  input  logic [2*NIB_W-1:0]   wr_data,
  input  logic                 rd0_pair,
  input  logic [RIDX_W-1:0]    rd0_idx,
  output logic [2*NIB_W-1:0]   rd0_data,
  input  logic                 rd1_pair,
  input  logic [RIDX_W-1:0]    rd1_idx,
  output logic [2*NIB_W-1:0]   rd1_data,
  output logic                 bank_en,
  output logic [SEL_W-1:0]     bank_sel,
  output logic [SEL_W-1:0]     bank_act,
  output logic                 stk_err
);
  localparam int PAIR_W  = 2 * NIB_W;
  localparam int PIDX_W  = RIDX_W - 1;
  localparam int HADDR_W = SEL_W + PIDX_W;
  localparam int NPORT   = 2;

  bank_st_t cur;

  nrf_bank_ctrl #(.STK_DEPTH(STK_DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .sel_ld     (sel_ld),
    .sel_val    (sel_val),
    .irq_entry  (irq_entry),
    .irq_en_val (irq_en_val),
    .push       (sv_push),
    .pop        (sv_pop),
    .cur        (cur),
    .stk_err    (stk_err)
  );

  assign bank_en  = cur.en;
  assign bank_sel = cur.sel;
  assign bank_act = cur.sel & {SEL_W{cur.en}};

  // Write side: even registers live in half 0, odd registers in half 1.
  logic [PIDX_W-1:0]  wslot;
  logic [HADDR_W-1:0] waddr;
  assign wslot = wr_pair ? wr_idx[PIDX_W-1:0] : wr_idx[RIDX_W-1:1];
  assign waddr = {bank_act, wslot};

  // Read side arrays, one entry per port.
  logic               rpair [NPORT];
  logic [RIDX_W-1:0]  ridx  [NPORT];
  logic [HADDR_W-1:0] raddr [NPORT];
  logic [PAIR_W-1:0]  rdat  [NPORT];
  logic [NIB_W-1:0]   hdat  [2][NPORT];

  assign rpair[0] = rd0_pair;
  assign rpair[1] = rd1_pair;
  assign ridx[0]  = rd0_idx;
  assign ridx[1]  = rd1_idx;
  assign rd0_data = rdat[0];
  assign rd1_data = rdat[1];

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    logic [PIDX_W-1:0] rslot;
    assign rslot    = rpair[k] ? ridx[k][PIDX_W-1:0] : ridx[k][RIDX_W-1:1];
    assign raddr[k] = {bank_act, rslot};
    assign rdat[k]  = rpair[k] ? {hdat[0][k], hdat[1][k]}
                               : {{NIB_W{1'b0}}, (ridx[k][0] ? hdat[1][k] : hdat[0][k])};
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic             we_h;
    logic [NIB_W-1:0] wd_h;
    assign we_h = wr_en && (wr_pair || (wr_idx[0] == 1'(h)));
    assign wd_h = (wr_pair && (h == 0)) ? wr_data[PAIR_W-1:NIB_W] : wr_data[NIB_W-1:0];

    nrf_reg_half #(.NIB_W(NIB_W), .AW(HADDR_W)) u_half (
      .clk    (clk),
      .rst    (rst),
      .we     (we_h),
      .waddr  (waddr),
      .wdata  (wd_h),
      .raddr0 (raddr[0]),
      .raddr1 (raddr[1]),
      .rdata0 (hdat[h][0]),
      .rdata1 (hdat[h][1])
    );
  end

  // R5: a pair write never touches only one half
  p_pair_both_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_pair) |-> (g_half[0].we_h && g_half[1].we_h));
  // R3: with the flag clear, reads address bank 0
  p_bank0_r3: assert property (@(posedge clk) disable iff (rst)
    !bank_en |-> (raddr[0][HADDR_W-1:PIDX_W] == '0));
endmodule

// File: tb/tb_nib_bank_regfile.sv
`timescale 1ns/1ps
module tb_nib_bank_regfile;
  logic clk = 1'b0;
  logic rst;
  logic en_set, en_clr, sel_ld, irq_entry, irq_en_val, sv_push, sv_pop;
  logic [1:0] sel_val;
  logic wr_en, wr_pair, rd0_pair, rd1_pair;
  logic [2:0] wr_idx, rd0_idx, rd1_idx;
  logic [7:0] wr_data, rd0_data, rd1_data;
  logic bank_en, stk_err;
  logic [1:0] bank_sel, bank_act;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] mdl [4][8];
  logic       m_en;
  logic [1:0] m_sel;
  logic [2:0] m_stk [4];
  int         m_cnt;
  logic       m_err;

  always #10 clk = ~clk;

  nib_bank_regfile dut (
    .clk(clk), .rst(rst), .en_set(en_set), .en_clr(en_clr), .sel_ld(sel_ld),
    .sel_val(sel_val), .irq_entry(irq_entry), .irq_en_val(irq_en_val),
    .sv_push(sv_push), .sv_pop(sv_pop), .wr_en(wr_en), .wr_pair(wr_pair),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd0_pair(rd0_pair), .rd0_idx(rd0_idx),
    .rd0_data(rd0_data), .rd1_pair(rd1_pair), .rd1_idx(rd1_idx),
    .rd1_data(rd1_data), .bank_en(bank_en), .bank_sel(bank_sel),
    .bank_act(bank_act), .stk_err(stk_err)
  );

  function automatic logic [1:0] m_act();
    return m_en ? m_sel : 2'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    en_set = 0; en_clr = 0; sel_ld = 0; sel_val = 0; irq_entry = 0; irq_en_val = 0;
    sv_push = 0; sv_pop = 0; wr_en = 0; wr_pair = 0; wr_idx = 0; wr_data = 0;
  endtask

  // Advance one clock, updating the requirement model from the driven inputs.
  task automatic step();
    logic [1:0] b;
    logic [2:0] popv;
    bit pok, e;
    int p;
    b = m_act(); pok = 0; e = 0; popv = 0;
    if (wr_en) begin
      if (wr_pair) begin
        p = int'(wr_idx[1:0]);
        mdl[b][2*p] = wr_data[7:4];
        mdl[b][2*p+1] = wr_data[3:0];
      end else mdl[b][wr_idx] = wr_data[3:0];
    end
    if (sv_push && sv_pop) e = 1;
    else if (sv_push) begin
      if (m_cnt == 4) e = 1;
      else begin m_stk[m_cnt] = {m_en, m_sel}; m_cnt++; end
    end else if (sv_pop) begin
      if (m_cnt == 0) e = 1;
      else begin m_cnt--; popv = m_stk[m_cnt]; pok = 1; end
    end
    if (pok) {m_en, m_sel} = popv;
    else begin
      if (irq_entry) m_en = irq_en_val;
      else if (en_set) m_en = 1;
      else if (en_clr) m_en = 0;
      if (sel_ld) m_sel = sel_val;
    end
    m_err = e;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic chk_state(string tag);
    chk({tag, " bank_en"},  32'(bank_en),  32'(m_en));
    chk({tag, " bank_sel"}, 32'(bank_sel), 32'(m_sel));
    chk({tag, " bank_act"}, 32'(bank_act), 32'(m_act()));
    chk({tag, " stk_err"},  32'(stk_err),  32'(m_err));
  endtask

  task automatic rd_nib(string tag, int port, int idx);
    if (port == 0) begin rd0_pair = 0; rd0_idx = 3'(idx); end
    else begin rd1_pair = 0; rd1_idx = 3'(idx); end
    #1;
    chk(tag, 32'(port == 0 ? rd0_data : rd1_data), 32'({4'h0, mdl[m_act()][idx]}));
  endtask

  task automatic rd_pair(string tag, int port, int p);
    if (port == 0) begin rd0_pair = 1; rd0_idx = 3'(p); end
    else begin rd1_pair = 1; rd1_idx = 3'(p); end
    #1;
    chk(tag, 32'(port == 0 ? rd0_data : rd1_data),
        32'({mdl[m_act()][2*p], mdl[m_act()][2*p+1]}));
  endtask

  task automatic go_bank(logic en, logic [1:0] sel);
    en_set = en; en_clr = !en; sel_ld = 1; sel_val = sel;
    step();
  endtask

  task automatic nib_wr(int idx, logic [3:0] v);
    wr_en = 1; wr_pair = 0; wr_idx = 3'(idx); wr_data = {4'h0, v};
    step();
  endtask

  task automatic pair_wr(int p, logic [7:0] v);
    wr_en = 1; wr_pair = 1; wr_idx = 3'(p); wr_data = v;
    step();
  endtask

  task automatic t_reset();
    chk_state("R1 reset");
    for (int i = 0; i < 8; i++) rd_nib("R1 reset reg", 0, i);
  endtask

  task automatic t_nibble();
    for (int i = 0; i < 8; i++) nib_wr(i, 4'(i + 6));
    for (int i = 0; i < 8; i++) rd_nib("R2 nibble port0", 0, i);
    for (int i = 0; i < 8; i++) rd_nib("R6 nibble port1", 1, 7 - i);
  endtask

  task automatic t_pair();
    pair_wr(2, 8'h9C);
    rd_nib("R5 pair high D", 0, 4);
    rd_nib("R5 pair low E", 1, 5);
    nib_wr(6, 4'h3);
    nib_wr(7, 4'h7);
    rd_pair("R5 pair read HL", 0, 3);
    pair_wr(0, 8'hA5);
    rd_pair("R5 pair read XA", 1, 0);
    rd_pair("R6 pair other port DE", 0, 2);
  endtask

  task automatic t_bank_and();
    go_bank(1, 2'd3);
    chk_state("R3 enabled bank3");
    nib_wr(1, 4'hE);
    rd_nib("R11 bank3 write", 0, 1);
    en_clr = 1; step();
    chk_state("R3 flag clear keeps sel");
    rd_nib("R11 bank0 untouched", 0, 1);
    en_set = 1; step();
    rd_nib("R3 back to bank3", 1, 1);
  endtask

  task automatic t_en_cmds();
    en_set = 1; en_clr = 1; step();
    chk_state("R4 set beats clear");
    en_clr = 1; step();
    chk_state("R4 clear");
    sel_ld = 1; sel_val = 2'd2; step();
    chk_state("R4 select load");
  endtask

  task automatic t_read_old();
    logic [3:0] old;
    old = mdl[m_act()][3];
    wr_en = 1; wr_pair = 0; wr_idx = 3'd3; wr_data = {4'h0, ~old};
    rd0_pair = 0; rd0_idx = 3'd3;
    #1;
    chk("R6 same-cycle read old", 32'(rd0_data), 32'({4'h0, old}));
    step();
    rd_nib("R6 read new after write", 0, 3);
  endtask

  task automatic t_write_vs_sel();
    go_bank(1, 2'd1);
    wr_en = 1; wr_idx = 3'd2; wr_data = 8'h0B;
    sel_ld = 1; sel_val = 2'd2;
    step();
    rd_nib("R7 write lands in new bank?", 0, 2);
    sel_ld = 1; sel_val = 2'd1; step();
    rd_nib("R7 write used old bank", 0, 2);
    wr_en = 1; wr_idx = 3'd5; wr_data = 8'h0D; en_clr = 1;
    step();
    rd_nib("R7 write before flag clear", 1, 5);
    en_set = 1; step();
    rd_nib("R7 old bank kept value", 1, 5);
  endtask

  task automatic t_irq();
    go_bank(0, 2'd3);
    irq_entry = 1; irq_en_val = 1; en_clr = 1; step();
    chk_state("R8 irq overrides clear");
    irq_entry = 1; irq_en_val = 0; en_set = 1; step();
    chk_state("R8 irq overrides set");
  endtask

  task automatic t_stack();
    go_bank(1, 2'd1); sv_push = 1; step();
    chk_state("R9 push1");
    go_bank(0, 2'd2); sv_push = 1; step();
    go_bank(1, 2'd3); sv_push = 1; step();
    go_bank(1, 2'd2); sv_push = 1; step();
    chk_state("R9 push4");
    go_bank(0, 2'd1);
    sv_push = 1; sel_ld = 1; sel_val = 2'd3; step();
    chk_state("R10 push when full");
    step();
    chk_state("R10 error one cycle");
    sv_pop = 1; en_clr = 1; sel_ld = 1; sel_val = 2'd0; step();
    chk_state("R9 pop overrides commands");
    for (int i = 0; i < 3; i++) begin
      sv_pop = 1; step();
      chk_state("R9 pop LIFO");
    end
    sv_pop = 1; en_set = 1; step();
    chk_state("R10 pop when empty");
    sv_push = 1; sv_pop = 1; step();
    chk_state("R10 push and pop together");
    sv_pop = 1; step();
    chk_state("R10 stack still empty");
  endtask

  initial begin
    idle();
    rd0_pair = 0; rd0_idx = 0; rd1_pair = 0; rd1_idx = 0;
    for (int b = 0; b < 4; b++) for (int r = 0; r < 8; r++) mdl[b][r] = 4'h0;
    m_en = 0; m_sel = 0; m_cnt = 0; m_err = 0;
    for (int i = 0; i < 4; i++) m_stk[i] = 3'd0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_nibble();
    t_pair();
    t_bank_and();
    t_en_cmds();
    t_read_old();
    t_write_vs_sel();
    t_irq();
    t_stack();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule